// File: doc/BRIEF.md
# Atomic Exchange Memory Unit

This unit performs an uninterruptible swap between the accumulator and a byte in memory, which is the primitive used to take a semaphore. The address is formed indirectly. A zero-page location named by the caller holds a two-byte pointer, and the Y index register is added to that pointer. The unit reads the byte at the resulting address and writes the accumulator value back to the same address in the next cycle. It then returns the old byte as the new accumulator value. The zero and negative flags are set from that old byte. With the usual semaphore convention (0 = free, 1 = held), a set zero flag means the caller now owns the semaphore.

While the read and the write are on the bus, the unit drives a lock output. The surrounding core uses it to hold off interrupt and task-switch recognition, so no other agent can observe or change the byte between the read and the write. The unit drives a simple synchronous byte-wide bus: a read issued in one cycle returns its data on `mem_rdata` during the following cycle, and a write takes effect at the clock edge that ends the write cycle.

Top module: `atomic_xchg`

## Requirements
- R1: After synchronous active-low reset, `busy`, `done`, `lock`, `mem_rd` and `mem_wr` are low, and `acc_out`, `flag_z` and `flag_n` are zero.
- R2: A `start` seen while idle begins the sequence. In the next cycle the unit reads address `{8'h00, zp_ptr}`, and in the cycle after that it reads `{8'h00, zp_ptr+1}`. The +1 wraps within page zero, so 0xFF is followed by 0x00.
- R3: The effective address is `{hi, lo} + idx_y`, computed over 16 bits. A carry out of the low byte goes into the high byte, and the sum wraps past 0xFFFF. It is formed in one idle bus cycle that follows the second pointer read.
- R4: The effective address is read in one cycle and written in the very next cycle, at the same address. The write data is the `acc_in` value captured when `start` was accepted. `mem_rd` and `mem_wr` are never high together.
- R5: `acc_out` takes the byte read from the effective address and holds it until the next completed exchange.
- R6: `flag_z` is 1 exactly when the old byte is 0x00. `flag_n` equals bit 7 of the old byte. Both update together with `acc_out`.
- R7: `lock` is high in the read cycle and the write cycle of the exchange, and in no other cycle. It is low in the cycle after the write.
- R8: `done` is a one-cycle pulse in the cycle after the write, which is the sixth cycle after the `start` edge. `busy` is high from the first sequence cycle through the `done` cycle, and the unit is idle in the cycle after `done`.
- R9: `start` asserted while `busy` is high is ignored. Operand inputs that change after acceptance affect neither the addresses nor the write data of the running exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request an exchange (accepted only when idle) |
| zp_ptr | input | 8 | Zero-page location of the pointer's low byte |
| idx_y | input | 8 | Index added to the pointer |
| acc_in | input | 8 | Value to store into memory |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| lock | output | 1 | Hold off interrupts and task switches |
| acc_out | output | 8 | Old memory byte (new accumulator) |
| flag_z | output | 1 | Old byte was zero |
| flag_n | output | 1 | Bit 7 of the old byte |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Bus read strobe |
| mem_wr | output | 1 | Bus write strobe |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data, valid the cycle after a read |

## Verification
A wrong sequencer state shows at the ports within one cycle. It appears as a bus strobe in the wrong cycle, a `lock` level that does not match the bus phase, or a `done` pulse that arrives early, arrives late, or lasts more than one cycle. A wrong pointer byte or a lost carry shows as a wrong effective address in the fourth cycle. A wrong captured byte appears in `acc_out` and the flags in the sixth cycle, and it stays visible there until the next exchange. Any mismatch in write data or address shows up as soon as the bench reads back its memory model.

// File: rtl/xchg_pkg.sv
// Package: xchg_pkg
// Shared types for the atomic exchange unit. The state order follows
// the bus sequence: pointer low, pointer high, add, read, write, done.
package xchg_pkg;

    // Sequencer states, in execution order
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PLO  = 3'd1,
        ST_PHI  = 3'd2,
        ST_ADD  = 3'd3,
        ST_RD   = 3'd4,
        ST_WR   = 3'd5,
        ST_DONE = 3'd6
    } xchg_state_e;

endpackage

// File: rtl/xchg_ctrl.sv
// Module: xchg_ctrl
// Sequencer for the exchange. It accepts start only in idle and steps
// through six fixed states, one per clock. It decodes the capture
// strobes for the datapath and the lock, busy and done outputs.
// Assumes: memory read data is valid in the cycle after the read.
module xchg_ctrl
    import xchg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output xchg_state_e state,
    output logic        accept,
    output logic        cap_lo,
    output logic        cap_hi,
    output logic        cap_old,
    output logic        busy,
    output logic        lock,
    output logic        done
);

    xchg_state_e state_q;
    xchg_state_e state_d;

    // Next-state selection: a fixed walk once started
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PLO;
            ST_PLO:  state_d = ST_PHI;
            ST_PHI:  state_d = ST_ADD;
            ST_ADD:  state_d = ST_RD;
            ST_RD:   state_d = ST_WR;
            ST_WR:   state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Strobe and status decode from the current state
    always_comb begin
        accept  = (state_q == ST_IDLE) && start;
        cap_lo  = (state_q == ST_PHI);   // low pointer byte on rdata
        cap_hi  = (state_q == ST_ADD);   // high pointer byte on rdata
        cap_old = (state_q == ST_WR);    // old memory byte on rdata
        busy    = (state_q != ST_IDLE);
        lock    = (state_q == ST_RD) || (state_q == ST_WR);
        done    = (state_q == ST_DONE);
    end

    assign state = state_q;

endmodule

// File: rtl/xchg_addr.sv
// Module: xchg_addr
// Address datapath. It latches the zero-page location and the index
// when a start is accepted, and collects the two pointer bytes from
// the read bus. It forms the effective address with a full-width add,
// so a carry from the low byte moves into the high byte.
// Assumes: cap_lo and cap_hi arrive in consecutive cycles.
module xchg_addr #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic                  cap_lo,
    input  logic                  cap_hi,
    input  logic [DATA_W-1:0]     zp_in,
    input  logic [DATA_W-1:0]     idx_in,
    input  logic [DATA_W-1:0]     rdata,
    output logic [DATA_W-1:0]     zp_lo_loc,
    output logic [DATA_W-1:0]     zp_hi_loc,
    output logic [2*DATA_W-1:0]   eff_addr
);

    localparam int ADDR_W = 2 * DATA_W;

    logic [DATA_W-1:0] zp_q;
    logic [DATA_W-1:0] idx_q;
    logic [DATA_W-1:0] ptr_lo_q;
    logic [ADDR_W-1:0] ea_q;
    logic [ADDR_W-1:0] ptr_full;
    logic [ADDR_W-1:0] ea_sum;

    // Operand capture at acceptance; later changes are not seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zp_q  <= '0;
            idx_q <= '0;
        end else if (accept) begin
            zp_q  <= zp_in;
            idx_q <= idx_in;
        end
    end

    // Low pointer byte capture
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_lo_q <= '0;
        else if (cap_lo) ptr_lo_q <= rdata;
    end

    // Full-width sum: pointer plus zero-extended index
    always_comb begin
        ptr_full = {rdata, ptr_lo_q};
        ea_sum   = ptr_full + ADDR_W'(idx_q);
    end

    // Effective address register, loaded while the high byte is on the bus
    always_ff @(posedge clk) begin
        if (!rst_n)      ea_q <= '0;
        else if (cap_hi) ea_q <= ea_sum;
    end

    // Pointer locations inside page zero; the high one wraps in-page
    assign zp_lo_loc = zp_q;
    assign zp_hi_loc = zp_q + DATA_W'(1);
    assign eff_addr  = ea_q;

endmodule

// File: rtl/xchg_result.sv
// Module: xchg_result
// Data path for the exchanged value. It holds the accumulator value
// taken at acceptance as write data, and captures the old memory byte
// with its zero and negative flags.
// Assumes: cap_old is high in the cycle the old byte is on rdata.
module xchg_result #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cap_old,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] acc_out,
    output logic              flag_z,
    output logic              flag_n
);

    logic [DATA_W-1:0] wr_q;
    logic [DATA_W-1:0] old_q;
    logic              z_q;
    logic              n_q;

    // Store value capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_q <= '0;
        else if (accept) wr_q <= acc_in;
    end

    // Old byte and flag capture, held until the next exchange
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
            z_q   <= 1'b0;
            n_q   <= 1'b0;
        end else if (cap_old) begin
            old_q <= rdata;
            z_q   <= (rdata == '0);
            n_q   <= rdata[DATA_W-1];
        end
    end

    assign wdata   = wr_q;
    assign acc_out = old_q;
    assign flag_z  = z_q;
    assign flag_n  = n_q;

endmodule

// File: rtl/atomic_xchg.sv
// Module: atomic_xchg
// Top level of the atomic exchange unit. It joins the sequencer and the
// two datapaths, and drives the bus address and strobes from the
// sequencer state. The fixed order is: read pointer low, read pointer
// high, add, locked read, locked write, done.
// Assumes: a synchronous bus whose read data returns one cycle late.
module atomic_xchg
    import xchg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [DATA_W-1:0]     zp_ptr,
    input  logic [DATA_W-1:0]     idx_y,
    input  logic [DATA_W-1:0]     acc_in,
    output logic                  busy,
    output logic                  done,
    output logic                  lock,
    output logic [DATA_W-1:0]     acc_out,
    output logic                  flag_z,
    output logic                  flag_n,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata
);

    localparam int ADDR_W = 2 * DATA_W;

    xchg_state_e       state;
    logic              accept;
    logic              cap_lo;
    logic              cap_hi;
    logic              cap_old;
    logic [DATA_W-1:0] zp_lo_loc;
    logic [DATA_W-1:0] zp_hi_loc;
    logic [ADDR_W-1:0] eff_addr;

    xchg_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .state   (state),
        .accept  (accept),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi),
        .cap_old (cap_old),
        .busy    (busy),
        .lock    (lock),
        .done    (done)
    );

    xchg_addr #(.DATA_W(DATA_W)) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .zp_in     (zp_ptr),
        .idx_in    (idx_y),
        .rdata     (mem_rdata),
        .zp_lo_loc (zp_lo_loc),
        .zp_hi_loc (zp_hi_loc),
        .eff_addr  (eff_addr)
    );

    xchg_result #(.DATA_W(DATA_W)) i_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .cap_old (cap_old),
        .acc_in  (acc_in),
        .rdata   (mem_rdata),
        .wdata   (mem_wdata),
        .acc_out (acc_out),
        .flag_z  (flag_z),
        .flag_n  (flag_n)
    );

    // Bus address and strobe decode per sequencer state
    always_comb begin
        mem_addr = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        unique case (state)
            ST_PLO: begin
                mem_addr = {{DATA_W{1'b0}}, zp_lo_loc};
                mem_rd   = 1'b1;
            end
            ST_PHI: begin
                mem_addr = {{DATA_W{1'b0}}, zp_hi_loc};
                mem_rd   = 1'b1;
            end
            ST_RD: begin
                mem_addr = eff_addr;
                mem_rd   = 1'b1;
            end
            ST_WR: begin
                mem_addr = eff_addr;
                mem_wr   = 1'b1;
            end
            default: begin
                mem_addr = '0;
            end
        endcase
    end

endmodule

// File: rtl/xchg_chk.sv
// Module: xchg_chk
// Property checker for atomic_xchg, attached with bind below.
module xchg_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic                lock,
    input logic [DATA_W-1:0]   acc_out,
    input logic                flag_z,
    input logic                flag_n,
    input logic [2*DATA_W-1:0] mem_addr,
    input logic                mem_rd,
    input logic                mem_wr,
    input logic [DATA_W-1:0]   mem_rdata
);

    a_r4_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r4_wr_follows_locked_rd: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd) && $past(lock) && (mem_addr == $past(mem_addr))));

    a_r7_lock_only_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (mem_rd || mem_wr));

    a_r7_lock_drops_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !lock);

    a_r8_done_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_wr) && busy));

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_acc_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_out == $past(mem_rdata)));

    a_r6_flags_match_old: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((flag_z == (acc_out == '0)) && (flag_n == acc_out[DATA_W-1])));

endmodule

bind atomic_xchg xchg_chk #(.DATA_W(DATA_W)) i_xchg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .lock      (lock),
    .acc_out   (acc_out),
    .flag_z    (flag_z),
    .flag_n    (flag_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_rdata (mem_rdata)
);

// File: tb/test_atomic_xchg.sv
`timescale 1ns/1ps
module test_atomic_xchg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  zp_ptr = '0;
    logic [7:0]  idx_y = '0;
    logic [7:0]  acc_in = '0;
    logic        busy, done, lock, flag_z, flag_n, mem_rd, mem_wr;
    logic [7:0]  acc_out, mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] mem_addr;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] mem [logic [15:0]];

    always #2.5 clk = ~clk;

    atomic_xchg i_atomic_xchg (
        .clk(clk), .rst_n(rst_n), .start(start), .zp_ptr(zp_ptr),
        .idx_y(idx_y), .acc_in(acc_in), .busy(busy), .done(done),
        .lock(lock), .acc_out(acc_out), .flag_z(flag_z), .flag_n(flag_n),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] peek(input logic [15:0] a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction

    // Synchronous memory model: read data one cycle later
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= peek(mem_addr);
        if (mem_wr) mem[mem_addr] = mem_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One exchange; disturb drives start and junk operands mid-sequence
    task automatic do_xchg(input logic [7:0] zp, input logic [7:0] y,
                           input logic [7:0] a, input bit disturb);
        logic [7:0]  lo, hi, old;
        logic [7:0]  zp1;
        logic [15:0] ea;
        zp1 = zp + 8'd1;
        lo  = peek({8'h00, zp});
        hi  = peek({8'h00, zp1});
        ea  = {hi, lo} + {8'h00, y};
        old = peek(ea);
        @(negedge clk);
        start = 1'b1; zp_ptr = zp; idx_y = y; acc_in = a;
        @(negedge clk);                       // cycle 1: pointer low read
        start = disturb;
        if (disturb) begin zp_ptr = ~zp; idx_y = ~y; acc_in = ~a; end
        check(busy && mem_rd && !mem_wr && !lock, "R8", "c1 busy/rd", {busy, mem_rd, mem_wr, lock}, 4'b1100);
        check(mem_addr == {8'h00, zp}, "R2", "ptr low addr", mem_addr, {8'h00, zp});
        @(negedge clk);                       // cycle 2: pointer high read
        check(mem_rd && !lock && mem_addr == {8'h00, zp1}, "R2", "ptr high addr", mem_addr, {8'h00, zp1});
        @(negedge clk);                       // cycle 3: add
        check(!mem_rd && !mem_wr && !lock, "R3", "idle add cycle", {mem_rd, mem_wr, lock}, 3'b000);
        @(negedge clk);                       // cycle 4: locked read
        check(mem_rd && lock && !mem_wr, "R7", "lock on read", {mem_rd, lock, mem_wr}, 3'b110);
        check(mem_addr == ea, "R3", "effective address", mem_addr, ea);
        @(negedge clk);                       // cycle 5: locked write
        check(mem_wr && lock && !mem_rd && mem_addr == ea, "R4", "write same addr", mem_addr, ea);
        check(mem_wdata == a, "R9", "write data from captured acc", mem_wdata, a);
        @(negedge clk);                       // cycle 6: done
        start = 1'b0;
        check(done && !lock && busy, "R8", "done pulse", {done, lock, busy}, 3'b101);
        check(acc_out == old, "R5", "old byte returned", acc_out, old);
        check(flag_z == (old == 8'h00) && flag_n == old[7], "R6", "flags", {flag_z, flag_n}, {(old == 8'h00), old[7]});
        check(peek(ea) == a, "R4", "memory updated", peek(ea), a);
        @(negedge clk);                       // cycle 7: idle again
        check(!done && !busy && !mem_rd && !mem_wr, "R9", "idle after done, no restart", {done, busy, mem_rd, mem_wr}, 4'b0000);
        check(acc_out == old, "R5", "acc held", acc_out, old);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        mem[16'h0010] = 8'h00; mem[16'h0011] = 8'h30;   // ptr 0x3000
        mem[16'h3005] = 8'h00;                          // free semaphore
        mem[16'h0020] = 8'hF0; mem[16'h0021] = 8'h12;   // ptr 0x12F0
        mem[16'h1310] = 8'h01;                          // held semaphore
        mem[16'h00FF] = 8'h40; mem[16'h0000] = 8'h25;   // ptr 0x2540, wraps
        mem[16'h2541] = 8'h80;
        mem[16'h0030] = 8'hF0; mem[16'h0031] = 8'hFF;   // ptr 0xFFF0
        mem[16'h0010 + 16'h0] = 8'h00;
        mem[16'h0050] = 8'h00;                          // target after wrap 0x0050? use 0x0060
        mem[16'h0040] = 8'h00; mem[16'h0041] = 8'h50;   // ptr 0x5000
        mem[16'h5007] = 8'h7F;

        repeat (3) @(negedge clk);
        check(!busy && !done && !lock && !mem_rd && !mem_wr, "R1", "reset outputs", {busy, done, lock, mem_rd, mem_wr}, 5'b0);
        check(acc_out == 8'h00 && !flag_z && !flag_n, "R1", "reset result", {acc_out, flag_z, flag_n}, 10'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_rd, "R1", "idle after reset", {busy, mem_rd}, 2'b00);

        do_xchg(8'h10, 8'h05, 8'h01, 1'b0);   // R6 free semaphore: Z=1
        do_xchg(8'h10, 8'h05, 8'h01, 1'b0);   // R6 now held: Z=0, back-to-back
        do_xchg(8'h20, 8'h20, 8'h01, 1'b0);   // R3 carry into high byte
        do_xchg(8'hFF, 8'h01, 8'h5A, 1'b0);   // R2 page-zero wrap, N=1
        do_xchg(8'h30, 8'h70, 8'hC3, 1'b0);   // R3 16-bit wrap to 0x0060
        do_xchg(8'h40, 8'h07, 8'h00, 1'b1);   // R9 start and operands change mid-run
        do_xchg(8'h40, 8'h07, 8'h11, 1'b0);   // R9 confirms first write was the captured 0x00

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule